// File: doc/BRIEF.md
# Run-Length Compressing Logic Capture Engine

This block records a bank of digital event inputs into on-chip RAM for later inspection by a host. It does not store every sample. It stores one entry per stable stretch of the input vector: the value, plus the number of sample cycles that value lasted. A RAM with a modest number of entries can therefore cover many thousands of sample periods when the inputs change rarely. Inputs that the host does not care about can be masked when the capture is armed. A masked input is stored as zero and never opens a new entry, so busy signals such as clocks do not use up the RAM.

A capture is armed with a one-cycle pulse. The mask, the trigger input index and the edge polarity are latched at that moment. While armed, entries go into the RAM as a circular buffer. A rising or falling edge on the selected raw input fires the trigger. After the trigger, exactly half the RAM depth of further entries is written, and the block then stops and reports done. The host reads the frozen window through a synchronous read port, using a logical index. Index zero is the oldest of the half-depth pre-trigger entries, and the post-trigger entries follow it.

Top module: `rle_capture`

## Requirements
- R1: After synchronous reset, `status` is 0 (idle), `done` is 0 and `rd_data` is 0.
- R2: An `arm` pulse seen in the idle (0) or done (3) state latches `mask`, `trig_sel` and `trig_fall`, and moves `status` to 1 (armed) on the next cycle. An `arm` pulse in the armed or triggered state is ignored.
- R3: Each stored entry is `{value, duration}`. The value is the masked input vector in the upper EVT_W bits. The duration is the count of sample cycles that value was held, in the lower DUR_W bits, and is never zero. A new entry begins only when the masked input vector differs from the previous sample, or under R7.
- R4: A `mask` bit of 1 excludes that input. The input reads as 0 in every entry and never starts an entry. Changes to `mask`, `trig_sel` or `trig_fall` after the arming cycle have no effect on that capture.
- R5: While armed, the trigger fires when `evt_in[trig_sel]` goes 0→1 between consecutive samples (`trig_fall`=0), or 1→0 (`trig_fall`=1). The raw input is used whether it is masked or not. `status` becomes 2 (triggered) in the cycle after the edge sample.
- R6: After the trigger, exactly DEPTH/2 entries are written. The first of these is the run that holds the trigger sample. When the last of them is written, `status` becomes 3 and `done` becomes 1, and the stored contents stay frozen until the next arm.
- R7: When a run reaches a duration of 2^DUR_W−1 cycles, that entry is closed at this maximum, and the same value continues in a new entry starting from a duration of 1.
- R8: `rd_addr` = i returns logical entry i on `rd_data` one clock later. Entries 0 to DEPTH/2−1 are the last DEPTH/2 pre-trigger runs, oldest first. Entries DEPTH/2 to DEPTH−1 are the post-trigger runs, in order.
- R9: Arming again from the done state starts a new, independent capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and system clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle request to start a capture |
| mask | input | EVT_W | 1 = input excluded from compression |
| trig_sel | input | $clog2(EVT_W) | Index of the trigger input |
| trig_fall | input | 1 | 0 = rising edge trigger, 1 = falling |
| evt_in | input | EVT_W | Event inputs, sampled every clock |
| rd_addr | input | $clog2(DEPTH) | Logical readback index |
| rd_data | output | EVT_W+DUR_W | Entry: value high, duration low |
| status | output | 2 | 0 idle, 1 armed, 2 triggered, 3 done |
| done | output | 1 | High when the capture has finished |

## Verification
The embedded assertions run on every cycle. They check that no entry is written outside a capture, that no entry ever carries a zero duration, that the triggered state can only be reached from the armed state, that the post-trigger count stays below half the depth, and that the done state holds when no arm arrives. Only the bench scenarios can show that the stored runs match the input stream. This covers masking, latching at arm, saturation splitting, a trigger that falls in the middle of a run, the exact stop point, and the readback ordering. To do this, the bench rebuilds the expected run list from the samples it drove and compares the state on every clock.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRIG  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_t;
endpackage

// File: rtl/rle_encoder.sv
module rle_encoder #(
  parameter int EVT_W = 16,
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [EVT_W-1:0] samp,
  input  logic [EVT_W-1:0] mask,
  output logic             we,
  output logic [EVT_W-1:0] wr_val,
  output logic [DUR_W-1:0] wr_dur
);
  localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};
  localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

  logic [EVT_W-1:0] cur_val;
  logic [DUR_W-1:0] cur_dur;
  logic [EVT_W-1:0] mval;

  assign mval   = samp & ~mask;
  assign we     = run && !start && ((mval != cur_val) || (cur_dur == DUR_MAX));
  assign wr_val = cur_val;
  assign wr_dur = cur_dur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_val <= '0;
      cur_dur <= '0;
    end else if (start) begin
      cur_val <= mval;
      cur_dur <= DUR_ONE;
    end else if (run) begin
      if (we) begin
        cur_val <= mval;
        cur_dur <= DUR_ONE;
      end else begin
        cur_dur <= cur_dur + DUR_ONE;
      end
    end
  end

  // R3: a closed run always spans at least one sample cycle
  assert_dur_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    we |-> (wr_dur != '0));
endmodule

// File: rtl/rle_trig.sv
module rle_trig #(
  parameter int EVT_W = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] samp,
  input  logic [SEL_W-1:0] sel,
  input  logic             fall,
  output logic             hit
);
  logic [EVT_W-1:0] prev;
  logic             now_b;
  logic             old_b;

  assign now_b = samp[sel];
  assign old_b = prev[sel];
  assign hit   = fall ? (old_b && !now_b) : (!old_b && now_b);

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= samp;
  end
endmodule

// File: rtl/rle_ram.sv
module rle_ram #(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/rle_capture.sv
module rle_capture #(
  parameter int EVT_W = 16,
  parameter int DEPTH = 1024,
  parameter int DUR_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         arm,
  input  logic [EVT_W-1:0]             mask,
  input  logic [$clog2(EVT_W)-1:0]     trig_sel,
  input  logic                         trig_fall,
  input  logic [EVT_W-1:0]             evt_in,
  input  logic [$clog2(DEPTH)-1:0]     rd_addr,
  output logic [EVT_W+DUR_W-1:0]       rd_data,
  output logic [1:0]                   status,
  output logic                         done
);
  import rle_pkg::*;

  localparam int AW    = $clog2(DEPTH);
  localparam int SEL_W = $clog2(EVT_W);
  localparam int EW    = EVT_W + DUR_W;
  localparam int HALF  = DEPTH / 2;
  localparam logic [AW-1:0] HALF_A = AW'(HALF);
  localparam logic [AW-1:0] LAST_A = AW'(HALF - 1);

  cap_state_t       state;
  logic [EVT_W-1:0] mask_r;
  logic [SEL_W-1:0] sel_r;
  logic             fall_r;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    trig_ptr;
  logic [AW-1:0]    post_cnt;

  logic             start;
  logic             run;
  logic             we;
  logic             hit;
  logic [EVT_W-1:0] wr_val;
  logic [DUR_W-1:0] wr_dur;
  logic [EVT_W-1:0] enc_mask;
  logic [AW-1:0]    raddr;

  assign start    = arm && ((state == ST_IDLE) || (state == ST_DONE));
  assign run      = (state == ST_ARMED) || (state == ST_TRIG);
  assign enc_mask = start ? mask : mask_r;
  assign raddr    = trig_ptr - HALF_A + rd_addr;
  assign status   = state;
  assign done     = (state == ST_DONE);

  rle_encoder #(.EVT_W(EVT_W), .DUR_W(DUR_W)) u_enc (
    .clk(clk), .rst(rst), .start(start), .run(run),
    .samp(evt_in), .mask(enc_mask),
    .we(we), .wr_val(wr_val), .wr_dur(wr_dur)
  );

  rle_trig #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst(rst), .samp(evt_in), .sel(sel_r),
    .fall(fall_r), .hit(hit)
  );

  rle_ram #(.DW(EW), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(wr_ptr),
    .wdata({wr_val, wr_dur}), .raddr(raddr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mask_r   <= '0;
      sel_r    <= '0;
      fall_r   <= 1'b0;
      wr_ptr   <= '0;
      trig_ptr <= '0;
      post_cnt <= '0;
    end else begin
      if (we) wr_ptr <= wr_ptr + AW'(1);
      if (start) begin
        state    <= ST_ARMED;
        mask_r   <= mask;
        sel_r    <= trig_sel;
        fall_r   <= trig_fall;
        wr_ptr   <= '0;
        post_cnt <= '0;
      end else begin
        case (state)
          ST_ARMED: if (hit) begin
            state    <= ST_TRIG;
            trig_ptr <= wr_ptr + AW'(we);
            post_cnt <= '0;
          end
          ST_TRIG: if (we) begin
            post_cnt <= post_cnt + AW'(1);
            if (post_cnt == LAST_A) state <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: nothing is stored outside an active capture
  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) || (state == ST_DONE)) |-> !we);

  // R5: the triggered state is entered only from the armed state
  assert_trig_from_armed_R5: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_TRIG) && ($past(state) != ST_TRIG)) |-> ($past(state) == ST_ARMED));

  // R6: the post-trigger count never reaches half the depth while triggered
  assert_post_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRIG) |-> (post_cnt < HALF_A));

  // R6: a finished capture stays finished until re-armed
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_DONE) && !arm) |=> (state == ST_DONE));
endmodule

// File: tb/rle_capture_test.sv
module rle_capture_test;
  localparam int EVT_W = 8;
  localparam int DEPTH = 16;
  localparam int DUR_W = 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int SEL_W = $clog2(EVT_W);
  localparam int EW    = EVT_W + DUR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int DMAX  = (1 << DUR_W) - 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             arm;
  logic [EVT_W-1:0] mask;
  logic [SEL_W-1:0] trig_sel;
  logic             trig_fall;
  logic [EVT_W-1:0] evt_in;
  logic [AW-1:0]    rd_addr;
  logic [EW-1:0]    rd_data;
  logic [1:0]       status;
  logic             done;

  always #4 clk = ~clk;

  rle_capture #(.EVT_W(EVT_W), .DEPTH(DEPTH), .DUR_W(DUR_W)) uut (
    .clk(clk), .rst(rst), .arm(arm), .mask(mask), .trig_sel(trig_sel),
    .trig_fall(trig_fall), .evt_in(evt_in), .rd_addr(rd_addr),
    .rd_data(rd_data), .status(status), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural reference: list of closed runs plus a predicted state
  logic [EW-1:0]    runs[$];
  logic [EVT_W-1:0] m_mask, m_cur, m_prev;
  logic [SEL_W-1:0] m_sel;
  logic             m_fall;
  int               m_dur, m_state, m_post, m_p;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_step(input logic [EVT_W-1:0] v, input bit a);
    logic [EVT_W-1:0] mv;
    bit edge_hit, wrote;
    if (a && (m_state == 0 || m_state == 3)) begin
      m_mask = mask; m_sel = trig_sel; m_fall = trig_fall;
      runs.delete();
      m_cur = v & ~m_mask; m_dur = 1; m_state = 1; m_post = 0;
    end else if (m_state == 1 || m_state == 2) begin
      mv = v & ~m_mask;
      edge_hit = m_fall ? (m_prev[m_sel] && !v[m_sel]) : (!m_prev[m_sel] && v[m_sel]);
      wrote = (mv != m_cur) || (m_dur == DMAX);
      if (wrote) begin
        runs.push_back({m_cur, DUR_W'(m_dur)});
        m_cur = mv; m_dur = 1;
      end else m_dur++;
      if (m_state == 2 && wrote) begin
        m_post++;
        if (m_post == HALF) m_state = 3;
      end
      if (m_state == 1 && edge_hit) begin
        m_state = 2; m_post = 0; m_p = runs.size();
      end
    end
    m_prev = v;
  endfunction

  // one sample: compare state from the previous edge, then drive next sample
  task automatic step(input logic [EVT_W-1:0] v, input bit a);
    string tag;
    @(negedge clk);
    tag = (m_state == 0) ? "R1" : (m_state == 1) ? "R2" : (m_state == 2) ? "R5" : "R6";
    chk(status == 2'(m_state), tag, 64'(status), 64'(m_state));
    chk(done == (m_state == 3), tag, 64'(done), 64'(m_state == 3));
    arm = a; evt_in = v;
    model_step(v, a);
  endtask

  task automatic hold(input logic [EVT_W-1:0] v, input int n);
    for (int i = 0; i < n; i++) step(v, 1'b0);
  endtask

  task automatic readout(input string tag);
    logic [EW-1:0] exp;
    @(negedge clk); arm = 1'b0;
    chk(status == 2'd3, "R6", 64'(status), 64'd3);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); rd_addr = AW'(i);
      @(negedge clk);
      exp = runs[m_p - HALF + i];
      chk(rd_data == exp, tag, 64'(rd_data), 64'(exp));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; arm = 1'b0; mask = '0; trig_sel = '0; trig_fall = 1'b0;
    evt_in = '0; rd_addr = '0; m_state = 0; m_prev = '0; m_p = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset values
    chk(status == 2'd0, "R1", 64'(status), 64'd0);
    chk(done == 1'b0, "R1", 64'(done), 64'd0);
    chk(rd_data == '0, "R1", 64'(rd_data), 64'd0);

    // Scenario A from idle: no mask, rising edge on input 3, long idle
    // saturates the duration (R7), every entry checked for R3 and R8
    mask = '0; trig_sel = 3'd3; trig_fall = 1'b0;
    step(8'h00, 1'b1);
    hold(8'h01, 3); hold(8'h02, 2); hold(8'h03, 1); hold(8'h05, 4);
    hold(8'h00, 40); hold(8'h06, 2); hold(8'h07, 3); hold(8'h01, 2);
    hold(8'h04, 2);
    hold(8'h08, 3);
    hold(8'h09, 2); hold(8'h0A, 2); hold(8'h02, 2); hold(8'h0B, 2);
    hold(8'h0C, 2); hold(8'h1C, 2); hold(8'h3C, 2); hold(8'h7C, 2);
    hold(8'hFC, 2); hold(8'h00, 5);
    readout("R3/R7/R8");

    // Scenario B, re-armed from done (R9): input 0 masked, falling edge on
    // masked input 0 fires in the middle of a run; ports changed after arm
    // and a stray arm while armed are both without effect (R4, R2)
    mask = 8'h01; trig_sel = 3'd0; trig_fall = 1'b1;
    step(8'h01, 1'b1);
    step(8'h03, 1'b0);
    mask = 8'hFF; trig_sel = 3'd7; trig_fall = 1'b0;
    hold(8'h03, 1); hold(8'h05, 2); hold(8'h09, 3); hold(8'h11, 2);
    step(8'h21, 1'b1); hold(8'h21, 1);
    hold(8'h41, 2); hold(8'h81, 3); hold(8'h01, 2); hold(8'h03, 2);
    hold(8'h02, 1);
    for (int i = 0; i < 10; i++) begin step(8'h03, 1'b0); step(8'h02, 1'b0); end
    for (int i = 0; i < 6; i++) begin step(8'h10, 1'b0); step(8'h11, 1'b0); end
    hold(8'h20, 3); hold(8'h40, 2); hold(8'h80, 2); hold(8'h44, 2);
    hold(8'h00, 2); hold(8'h06, 2); hold(8'h08, 2); hold(8'h0E, 2);
    hold(8'h00, 10);
    readout("R4/R9");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule